// File: doc/BRIEF.md
# Multi-Channel Shared-Memory FIFO

This block holds several independent first-in first-out queues in one dual-port memory. It runs on one clock and has an asynchronous active-high reset. Every channel owns a fixed region of the memory and has its own write pointer, read pointer and occupancy counter. One memory port serves all writes and the other serves all reads, so each cycle can take one push and one pop. The push and the pop may address different channels or the same channel.

The pointers are linear-feedback shift registers, not binary counters. The memory address is the channel index placed above that channel's pointer state. A maximal-length register of `PTR_W` bits never reaches the all-zero state, so each channel stores `2^PTR_W - 1` words. The empty and full flags come from a separate binary counter per channel. A push that is refused or a pop that is refused does not change the channel, and it raises a one-cycle error pulse for that channel.

Top module: `chan_lfsr_fifo`

## Requirements
- R1: After reset every channel reports empty and not full, no error pulse is raised, and the read data output is zero.
- R2: Words popped from one channel come out in the order they were pushed. Popped data appears on the read data output in the cycle after the pop strobe and stays there until the next accepted pop.
- R3: A push or a pop on one channel does not change the flags, the contents or the order of any other channel.
- R4: Each channel holds exactly `2^PTR_W - 1` words (15 with the defaults). A channel filled to that count gives back every word unchanged, and a pointer never takes the all-zero state.
- R5: A push to a full channel is ignored. It raises that channel's bit of `overflow_o` for exactly the next cycle, and the stored contents stay intact.
- R6: A pop from an empty channel is ignored. It raises that channel's bit of `underflow_o` for exactly the next cycle, and the read data output keeps its previous value.
- R7: An accepted push and an accepted pop on the same channel in the same cycle leave that channel's fill level and flags unchanged, and the queue order is kept.
- R8: A channel's bit of `empty_o` is set exactly when its fill level is zero. Its bit of `full_o` is set exactly when its fill level equals the per-channel depth. The two are never set together.
- R9: Asserting reset at any point clears every channel to empty at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| push_i | input | 1 | Write strobe |
| wr_ch_i | input | $clog2(NUM_CH) | Channel index for the write |
| wr_data_i | input | DATA_W | Word to store |
| pop_i | input | 1 | Read strobe |
| rd_ch_i | input | $clog2(NUM_CH) | Channel index for the read |
| rd_data_o | output | DATA_W | Popped word, valid the cycle after an accepted pop |
| empty_o | output | NUM_CH | Per-channel empty flag |
| full_o | output | NUM_CH | Per-channel full flag |
| overflow_o | output | NUM_CH | One-cycle pulse after a refused push |
| underflow_o | output | NUM_CH | One-cycle pulse after a refused pop |

## Verification
The assertions check five rules on every cycle. No pointer reaches the all-zero state, and no counter goes past the depth. Empty and full are never set together. A refused strobe raises its pulse on the next cycle, and a balanced push and pop leave the count unchanged. Data order, the exact depth, the independence of channels and the asynchronous reset can only be shown by the bench. The bench runs a queue model per channel through directed fill and drain sequences and a long random mix of traffic.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;

   // Feedback masks for maximal-length shift registers of 2 to 8 bits.
   // Bit k set means stage k feeds the XOR that enters stage 0.
   function automatic logic [7:0] lfsr_mask(input int w);
      case (w)
         2:       return 8'b0000_0011;
         3:       return 8'b0000_0110;
         4:       return 8'b0000_1100;
         5:       return 8'b0001_0100;
         6:       return 8'b0011_0000;
         7:       return 8'b0110_0000;
         default: return 8'b1011_1000;
      endcase
   endfunction

endpackage

// File: rtl/cf_lfsr_ptr.sv
module cf_lfsr_ptr
   import chan_fifo_pkg::*;
#(
   parameter int W    = 4,
   parameter int SEED = 1
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         step_i,
   output logic [W-1:0] ptr_o
);
   localparam logic [7:0]   MASK8 = lfsr_mask(W);
   localparam logic [W-1:0] MASK  = MASK8[W-1:0];

   if (SEED == 0 || SEED >= (1 << W)) begin : g_bad_seed
      $error("cf_lfsr_ptr: SEED must be nonzero and fit in W bits");
   end

   logic [W-1:0] state_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)       state_q <= W'(SEED);
      else if (step_i) state_q <= {state_q[W-2:0], ^(state_q & MASK)};
   end

   assign ptr_o = state_q;

   // R4: the forbidden all-zero state is never reached
   p_ptr_nonzero_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      state_q != '0);
endmodule

// File: rtl/cf_occ_cnt.sv
module cf_occ_cnt #(
   parameter int DEPTH = 15,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic inc_i,
   input  logic dec_i,
   output logic empty_o,
   output logic full_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)                 cnt_q <= '0;
      else if (inc_i && !dec_i)  cnt_q <= cnt_q + 1'b1;
      else if (dec_i && !inc_i)  cnt_q <= cnt_q - 1'b1;
   end

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CW'(DEPTH));

   // R5: the fill level never passes the depth
   p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= CW'(DEPTH));
   // R7: a balanced push and pop hold the level
   p_balanced_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (inc_i && dec_i) |=> $stable(cnt_q));
   // R8: the flags never contradict each other
   p_flag_excl_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !(empty_o && full_o));
endmodule

// File: rtl/cf_dpram.sv
module cf_dpram #(
   parameter int AW = 7,
   parameter int DW = 16
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          re_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   localparam int WORDS = 1 << AW;

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk_i) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)     rdata_o <= '0;
      else if (re_i) rdata_o <= mem[raddr_i];
   end
endmodule

// File: rtl/chan_lfsr_fifo.sv
module chan_lfsr_fifo #(
   parameter int NUM_CH  = 8,
   parameter int DATA_W  = 16,
   parameter int PTR_W   = 4,
   parameter int SEED    = 1,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int DEPTH  = (1 << PTR_W) - 1,
   localparam int ADDR_W = CH_W + PTR_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              push_i,
   input  logic [CH_W-1:0]   wr_ch_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              pop_i,
   input  logic [CH_W-1:0]   rd_ch_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [NUM_CH-1:0] empty_o,
   output logic [NUM_CH-1:0] full_o,
   output logic [NUM_CH-1:0] overflow_o,
   output logic [NUM_CH-1:0] underflow_o
);
   if (NUM_CH < 2 || NUM_CH != (1 << CH_W)) begin : g_bad_ch
      $error("chan_lfsr_fifo: NUM_CH must be a power of two, at least 2");
   end
   if (PTR_W < 2 || PTR_W > 8) begin : g_bad_ptr
      $error("chan_lfsr_fifo: PTR_W must lie in 2..8");
   end

   logic [NUM_CH-1:0] acc_push, acc_pop, rej_push, rej_pop;
   logic [PTR_W-1:0]  wptr [NUM_CH];
   logic [PTR_W-1:0]  rptr [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic push_here, pop_here;
      assign push_here   = push_i && (wr_ch_i == CH_W'(c));
      assign pop_here    = pop_i  && (rd_ch_i == CH_W'(c));
      assign acc_push[c] = push_here && !full_o[c];
      assign acc_pop[c]  = pop_here  && !empty_o[c];
      assign rej_push[c] = push_here && full_o[c];
      assign rej_pop[c]  = pop_here  && empty_o[c];

      cf_lfsr_ptr #(.W(PTR_W), .SEED(SEED)) u_wptr (
         .clk_i(clk_i), .rst_i(rst_i), .step_i(acc_push[c]), .ptr_o(wptr[c]));
      cf_lfsr_ptr #(.W(PTR_W), .SEED(SEED)) u_rptr (
         .clk_i(clk_i), .rst_i(rst_i), .step_i(acc_pop[c]), .ptr_o(rptr[c]));
      cf_occ_cnt #(.DEPTH(DEPTH)) u_cnt (
         .clk_i(clk_i), .rst_i(rst_i), .inc_i(acc_push[c]), .dec_i(acc_pop[c]),
         .empty_o(empty_o[c]), .full_o(full_o[c]));
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         overflow_o  <= '0;
         underflow_o <= '0;
      end else begin
         overflow_o  <= rej_push;
         underflow_o <= rej_pop;
      end
   end

   cf_dpram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
      .clk_i(clk_i), .rst_i(rst_i),
      .we_i(|acc_push), .waddr_i({wr_ch_i, wptr[wr_ch_i]}), .wdata_i(wr_data_i),
      .re_i(|acc_pop),  .raddr_i({rd_ch_i, rptr[rd_ch_i]}), .rdata_o(rd_data_o));

   // R5: a push into a full channel pulses its overflow bit next cycle
   p_ovf_pulse_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (push_i && full_o[wr_ch_i]) |=> overflow_o[$past(wr_ch_i)]);
   // R6: a pop from an empty channel pulses its underflow bit next cycle
   p_udf_pulse_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (pop_i && empty_o[rd_ch_i]) |=> underflow_o[$past(rd_ch_i)]);
   // R6: with no accepted pop the read data holds
   p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !(pop_i && !empty_o[rd_ch_i]) |=> $stable(rd_data_o));
   // R5 R6: at most one channel errs per side per cycle
   p_err_onehot_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(overflow_o) && $onehot0(underflow_o));
endmodule

// File: tb/chan_lfsr_fifo_bench.sv
`timescale 1ns/1ps
module chan_lfsr_fifo_bench;
   localparam int NUM_CH = 8;
   localparam int DATA_W = 16;
   localparam int PTR_W  = 4;
   localparam int CH_W   = $clog2(NUM_CH);
   localparam int DEPTH  = (1 << PTR_W) - 1;

   logic              clk = 1'b0;
   logic              rst;
   logic              push, pop;
   logic [CH_W-1:0]   wch, rch;
   logic [DATA_W-1:0] wdata, rd_data;
   logic [NUM_CH-1:0] empty, full, ovf, udf;

   int checks = 0;
   int failures = 0;
   logic [DATA_W-1:0] model_q [NUM_CH][$];
   logic [DATA_W-1:0] last_rd;

   always #2 clk = ~clk;

   chan_lfsr_fifo #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_chan_lfsr_fifo (
      .clk_i(clk), .rst_i(rst), .push_i(push), .wr_ch_i(wch), .wr_data_i(wdata),
      .pop_i(pop), .rd_ch_i(rch), .rd_data_o(rd_data),
      .empty_o(empty), .full_o(full), .overflow_o(ovf), .underflow_o(udf));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [NUM_CH-1:0] exp_empty();
      logic [NUM_CH-1:0] v;
      for (int c = 0; c < NUM_CH; c++) v[c] = (model_q[c].size() == 0);
      return v;
   endfunction

   function automatic logic [NUM_CH-1:0] exp_full();
      logic [NUM_CH-1:0] v;
      for (int c = 0; c < NUM_CH; c++) v[c] = (model_q[c].size() == DEPTH);
      return v;
   endfunction

   // One cycle: drive after a falling edge, check at the next falling edge.
   task automatic step(input logic p, input int wc, input logic [DATA_W-1:0] d,
                       input logic q, input int rc);
      logic [NUM_CH-1:0] e_ovf = '0, e_udf = '0;
      logic              acc_pop;
      int                pre_w, pre_r;
      push = p; wch = CH_W'(wc); wdata = d; pop = q; rch = CH_W'(rc);
      pre_w = model_q[wc].size();
      pre_r = model_q[rc].size();
      acc_pop = q && (pre_r != 0);
      if (p && pre_w == DEPTH) e_ovf[wc] = 1'b1;
      if (q && pre_r == 0)     e_udf[rc] = 1'b1;
      if (acc_pop) last_rd = model_q[rc].pop_front();
      if (p && pre_w != DEPTH) model_q[wc].push_back(d);
      @(posedge clk);
      @(negedge clk);
      push = 1'b0; pop = 1'b0;
      chk("R2 read data order", 64'(rd_data), 64'(last_rd));
      chk("R8 empty flags", 64'(empty), 64'(exp_empty()));
      chk("R8 full flags", 64'(full), 64'(exp_full()));
      chk("R5 overflow pulse", 64'(ovf), 64'(e_ovf));
      chk("R6 underflow pulse", 64'(udf), 64'(e_udf));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst = 1'b1; push = 1'b0; pop = 1'b0; wch = '0; rch = '0; wdata = '0;
      last_rd = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 empty after reset", 64'(empty), {NUM_CH{1'b1}});
      chk("R1 full after reset", 64'(full), 64'd0);
      chk("R1 pulses after reset", 64'({ovf, udf}), 64'd0);
      chk("R1 read data after reset", 64'(rd_data), 64'd0);

      // R4 fill channel 3 to exactly its depth
      for (int i = 0; i < DEPTH; i++) step(1'b1, 3, DATA_W'(16'hA000 + i), 1'b0, 0);
      chk("R4 full after depth pushes", 64'(full[3]), 64'd1);
      chk("R3 other channels still empty", 64'(empty & ~8'h08), 64'(8'hF7));
      // R5 push into the full channel
      step(1'b1, 3, 16'hDEAD, 1'b0, 0);
      chk("R5 still full after refused push", 64'(full[3]), 64'd1);
      // R3 use channel 5 while channel 3 is full
      step(1'b1, 5, 16'h5501, 1'b0, 0);
      // R7 balanced push and pop on channel 5
      step(1'b1, 5, 16'h5502, 1'b1, 5);
      chk("R7 level held, not empty", 64'(empty[5]), 64'd0);
      chk("R7 level held, not full", 64'(full[5]), 64'd0);
      chk("R7 first word out", 64'(rd_data), 64'h5501);
      step(1'b0, 0, '0, 1'b1, 5);
      chk("R7 second word out", 64'(rd_data), 64'h5502);
      // R2 R4 drain channel 3 and confirm every word in order
      for (int i = 0; i < DEPTH; i++) begin
         step(1'b0, 0, '0, 1'b1, 3);
         chk("R4 drained word", 64'(rd_data), 64'(16'hA000 + i));
      end
      // R6 pop from the now empty channel
      step(1'b0, 0, '0, 1'b1, 3);
      chk("R6 data held on refused pop", 64'(rd_data), 64'(16'hA000 + DEPTH - 1));

      // Random traffic over all channels
      for (int n = 0; n < 3000; n++) begin
         step(($urandom % 100) < 60, int'($urandom % NUM_CH), DATA_W'($urandom),
              ($urandom % 100) < 45, int'($urandom % NUM_CH));
      end

      // R9 asynchronous reset in the middle of a cycle
      step(1'b1, 2, 16'h2222, 1'b0, 0);
      #1 rst = 1'b1;
      #0.5;
      chk("R9 empty at once on reset", 64'(empty), {NUM_CH{1'b1}});
      chk("R9 read data cleared", 64'(rd_data), 64'd0);
      for (int c = 0; c < NUM_CH; c++) model_q[c].delete();
      last_rd = '0;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      step(1'b1, 2, 16'h7777, 1'b0, 0);
      step(1'b0, 0, '0, 1'b1, 2);
      chk("R9 fresh data after reset", 64'(rd_data), 64'h7777);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule